// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block chooses which of ten interrupt vectors is offered to a processor core. Each vector sits at a fixed entry address and carries one of three priority levels: low, high or highest. A request is offered only when its level is strictly above the level now being serviced. When the core accepts the offer, the block raises its in-service level to the level of the accepted vector and keeps the previous level on a small internal stack. A return-from-interrupt strobe restores that level, so handlers can nest up to three deep.

Several peripheral event flags can share one vector; the block ORs them together. The flags are owned by the peripherals: the block never latches or clears them, so they survive while the global enable is low. Once the request line to the core is up, the offered vector is frozen until the core acknowledges it or the global enable is removed.

Top module: `lvl_nest_intc`

## Requirements
- R1: Vector index i (0 to 9) is reported on `vec_addr_o` as the 8-bit entry address 03h + 8*i, so index 0 gives 03h and index 9 gives 4Bh.
- R2: `cur_lvl_o` encodes the in-service level as 0 = none, 1 = low, 2 = high, 3 = highest. Bit i of `raise_cfg_i` at 0 places vector i at low; at 1 it places vectors 0 and 1 at highest and vectors 2 to 9 at high.
- R3: A request is offered only if its level is strictly above `cur_lvl_o`; a request at or below that level leaves `irq_o` low.
- R4: Among offerable requests, the highest level wins; among equal levels, the lowest vector index (smallest entry address) wins.
- R5: The request of vector i is the OR of `src_req_i[3*i+2 : 3*i]`; any one of its three source bits is enough.
- R6: `irq_o` rises one clock edge after an offerable request is seen with the enable high; while `irq_o` stays high without acknowledge, `vec_addr_o` holds its value even if a higher request appears.
- R7: An edge with `ack_i` and `irq_o` both high makes `cur_lvl_o` the level of the offered vector, saves the prior level, and drops `irq_o` at that edge; `ack_i` while `irq_o` is low has no effect.
- R8: `reti_i` restores the most recently saved level; with nothing in service it has no effect and `cur_lvl_o` stays 0.
- R9: `ack_i` and `reti_i` at the same edge first restore the saved level and then accept the offer, so the stack depth is unchanged and one later `reti_i` returns to the level that was saved before the finished handler.
- R10: While `glob_en_i` is low, `irq_o` is low from the next edge on and the frozen offer is released; requests still present are offered once the enable returns.
- R11: After reset, `irq_o` is 0, `vec_addr_o` is 03h and `cur_lvl_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global interrupt enable |
| src_req_i | input | 30 | Peripheral event flags, three per vector |
| raise_cfg_i | input | 10 | Per-vector level select (0 = low, 1 = raised) |
| ack_i | input | 1 | Core accepts the offered vector |
| reti_i | input | 1 | Core returns from the current handler |
| irq_o | output | 1 | Interrupt offer to the core |
| vec_addr_o | output | 8 | Entry address of the offered vector |
| cur_lvl_o | output | 2 | Level now in service |

## Verification
The acknowledge of a new offer and the return from the running handler can land on the same clock edge, which is the tail-chaining case of R9. The bench enters a low-level handler, raises a high-level request, waits for the offer and then drives both strobes in one cycle; it judges the result by the in-service level right after the edge (the new high level) and after one more return (none, not low). A second overlap, a higher request arriving while an offer is frozen, is judged by the address staying put until the acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_L    = 2'd1,
      LVL_H    = 2'd2,
      LVL_X    = 2'd3
   } lvl_e;

   localparam int NUM_LEVELS = 3;

endpackage

// File: rtl/intc_src_merge.sv
module intc_src_merge #(
   parameter int NUM_VEC     = 10,
   parameter int SRC_PER_VEC = 3
) (
   input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_i,
   output logic [NUM_VEC-1:0]             req_o
);

   if (NUM_VEC < 1)     $error("intc_src_merge: NUM_VEC must be at least 1");
   if (SRC_PER_VEC < 1) $error("intc_src_merge: SRC_PER_VEC must be at least 1");

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      if (SRC_PER_VEC == 1) begin : g_single
         assign req_o[v] = src_i[v];
      end else begin : g_or
         assign req_o[v] = |src_i[v*SRC_PER_VEC +: SRC_PER_VEC];
      end
   end

endmodule

// File: rtl/intc_pick.sv
module intc_pick
   import intc_pkg::*;
#(
   parameter int NUM_VEC = 10,
   parameter int NUM_TOP = 2,
   parameter int IDX_W   = 4
) (
   input  logic [NUM_VEC-1:0] req_i,
   input  logic [NUM_VEC-1:0] raise_i,
   input  lvl_e               cur_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   idx_o,
   output lvl_e               lvl_o
);

   if (NUM_TOP > NUM_VEC) $error("intc_pick: NUM_TOP exceeds NUM_VEC");
   if ((1 << IDX_W) < NUM_VEC) $error("intc_pick: IDX_W too narrow");

   lvl_e               eff [NUM_VEC];
   logic [NUM_VEC-1:0] elig;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
      if (v < NUM_TOP) begin : g_top
         assign eff[v] = raise_i[v] ? LVL_X : LVL_L;
      end else begin : g_mid
         assign eff[v] = raise_i[v] ? LVL_H : LVL_L;
      end
      assign elig[v] = req_i[v] && (eff[v] > cur_i);
   end

   // Scan from the top index downwards; ">=" lets a lower index
   // replace an equal-level winner, so the lowest index wins a tie.
   always_comb begin
      any_o = |elig;
      idx_o = '0;
      lvl_o = LVL_NONE;
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
         if (elig[v] && (eff[v] >= lvl_o)) begin
            idx_o = IDX_W'(v);
            lvl_o = eff[v];
         end
      end
   end

endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack
   import intc_pkg::*;
#(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic pop_i,
   input  lvl_e din_i,
   output lvl_e top_o,
   output logic empty_o
);

   if (DEPTH < 1) $error("intc_lvl_stack: DEPTH must be at least 1");

   localparam int CNT_W = $clog2(DEPTH + 1);

   lvl_e             ent [DEPTH];
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) ent[k] <= LVL_NONE;
         cnt_q <= '0;
      end else if (push_i && pop_i) begin
         ent[0] <= din_i;
      end else if (push_i) begin
         ent[0] <= din_i;
         for (int k = 1; k < DEPTH; k++) ent[k] <= ent[k-1];
         cnt_q <= cnt_q + CNT_W'(1);
      end else if (pop_i) begin
         for (int k = 0; k < DEPTH - 1; k++) ent[k] <= ent[k+1];
         ent[DEPTH-1] <= LVL_NONE;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign top_o   = ent[0];
   assign empty_o = (cnt_q == '0);

   // R7: nesting never pushes past the stack depth
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> (cnt_q < CNT_W'(DEPTH)));

   // R8: a restore is only issued when a level is saved
   a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/lvl_nest_intc.sv
module lvl_nest_intc
   import intc_pkg::*;
#(
   parameter int NUM_VEC     = 10,
   parameter int NUM_TOP     = 2,
   parameter int SRC_PER_VEC = 3,
   parameter int ADDR_W      = 8,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STRIDE  = 8,
   parameter int STK_DEPTH   = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           glob_en_i,
   input  logic [NUM_VEC*SRC_PER_VEC-1:0] src_req_i,
   input  logic [NUM_VEC-1:0]             raise_cfg_i,
   input  logic                           ack_i,
   input  logic                           reti_i,
   output logic                           irq_o,
   output logic [ADDR_W-1:0]              vec_addr_o,
   output logic [1:0]                     cur_lvl_o
);

   localparam int IDX_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
   localparam int LAST_ADR = VEC_BASE + VEC_STRIDE * (NUM_VEC - 1);

   if (STK_DEPTH < NUM_LEVELS) $error("lvl_nest_intc: STK_DEPTH below nesting depth");
   if (LAST_ADR >= (1 << ADDR_W)) $error("lvl_nest_intc: vector table exceeds ADDR_W");
   if (NUM_TOP > NUM_VEC) $error("lvl_nest_intc: NUM_TOP exceeds NUM_VEC");

   logic [NUM_VEC-1:0] vec_req;
   logic               win_any;
   logic [IDX_W-1:0]   win_idx;
   lvl_e               win_lvl;

   logic               irq_q;
   logic [IDX_W-1:0]   idx_q;
   lvl_e               pend_q;
   lvl_e               cur_q;

   lvl_e               stk_top;
   logic               stk_empty;
   logic               take;
   logic               pop_eff;
   lvl_e               restored;

   intc_src_merge #(
      .NUM_VEC     (NUM_VEC),
      .SRC_PER_VEC (SRC_PER_VEC)
   ) u_merge (
      .src_i (src_req_i),
      .req_o (vec_req)
   );

   intc_pick #(
      .NUM_VEC (NUM_VEC),
      .NUM_TOP (NUM_TOP),
      .IDX_W   (IDX_W)
   ) u_pick (
      .req_i   (vec_req),
      .raise_i (raise_cfg_i),
      .cur_i   (cur_q),
      .any_o   (win_any),
      .idx_o   (win_idx),
      .lvl_o   (win_lvl)
   );

   assign take     = ack_i && irq_q;
   assign pop_eff  = reti_i && !stk_empty;
   assign restored = pop_eff ? stk_top : cur_q;

   intc_lvl_stack #(
      .DEPTH (STK_DEPTH)
   ) u_stack (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (take),
      .pop_i   (pop_eff),
      .din_i   (restored),
      .top_o   (stk_top),
      .empty_o (stk_empty)
   );

   // Offer register: frozen while raised and enabled, re-evaluated otherwise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         idx_q  <= '0;
         pend_q <= LVL_NONE;
      end else if (take) begin
         irq_q  <= 1'b0;
      end else if (irq_q && glob_en_i) begin
         irq_q  <= 1'b1;
      end else begin
         irq_q  <= glob_en_i && win_any;
         idx_q  <= win_idx;
         pend_q <= win_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= LVL_NONE;
      else        cur_q <= take ? pend_q : restored;
   end

   assign irq_o      = irq_q;
   assign vec_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q) * ADDR_W'(VEC_STRIDE);
   assign cur_lvl_o  = cur_q;

   // R3: an offer always outranks the level in service
   a_r3_offer_above: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (pend_q > cur_q));

   // R6: a pending offer keeps its vector until taken
   a_r6_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack_i && glob_en_i) |=> (irq_q && $stable(vec_addr_o)));

   // R7: acceptance withdraws the offer
   a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && ack_i) |=> !irq_q);

   // R8: nothing saved exactly when nothing in service
   a_r8_empty_none: assert property (@(posedge clk) disable iff (!rst_n)
      stk_empty == (cur_q == LVL_NONE));

   // R10: a disabled controller raises nothing
   a_r10_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_en_i |=> !irq_q);

endmodule

// File: tb/lvl_nest_intc_bench.sv
`timescale 1ns/100ps
module lvl_nest_intc_bench;

   localparam int NV = 10;
   localparam int SP = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            glob_en_i = 1'b0;
   logic [NV*SP-1:0] src_req_i = '0;
   logic [NV-1:0]   raise_cfg_i = '0;
   logic            ack_i = 1'b0;
   logic            reti_i = 1'b0;
   logic            irq_o;
   logic [7:0]      vec_addr_o;
   logic [1:0]      cur_lvl_o;

   always #2.5 clk = ~clk;

   lvl_nest_intc u_lvl_nest_intc (
      .clk         (clk),
      .rst_n       (rst_n),
      .glob_en_i   (glob_en_i),
      .src_req_i   (src_req_i),
      .raise_cfg_i (raise_cfg_i),
      .ack_i       (ack_i),
      .reti_i      (reti_i),
      .irq_o       (irq_o),
      .vec_addr_o  (vec_addr_o),
      .cur_lvl_o   (cur_lvl_o)
   );

   typedef struct {
      int    addr;
      int    lvl;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int addr_of(input int v);
      return 3 + 8 * v;
   endfunction

   task automatic set_src(input int v, input int slot, input logic val);
      src_req_i[v*SP + slot] = val;
   endtask

   task automatic wait_irq(input string tag);
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!irq_o && n < 50);
      if (!irq_o) chk(1'b0, tag, 0, 1);
   endtask

   // Driver: queue the expected offer, then accept it.
   task automatic service(input int v, input int lvl, input string tag);
      exp_t e;
      e.addr = addr_of(v);
      e.lvl  = lvl;
      e.tag  = tag;
      q.push_back(e);
      wait_irq(tag);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
   endtask

   task automatic reti_pulse();
      @(negedge clk);
      reti_i = 1'b1;
      @(negedge clk);
      reti_i = 1'b0;
   endtask

   task automatic quiet(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(irq_o == 1'b0, tag, irq_o, 0);
      end
   endtask

   task automatic cur_is(input int lvl, input string tag);
      @(negedge clk);
      chk(cur_lvl_o == 2'(lvl), tag, cur_lvl_o, lvl);
   endtask

   // Monitor: compares each accepted offer with the scoreboard.
   initial begin
      bit   cur_due = 1'b0;
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (cur_due) begin
            chk(cur_lvl_o == 2'(e.lvl), {e.tag, " level"}, cur_lvl_o, e.lvl);
            cur_due = 1'b0;
         end
         if (irq_o && ack_i) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7 unexpected acceptance", vec_addr_o, 0);
            end else begin
               e = q.pop_front();
               chk(vec_addr_o == 8'(e.addr), {e.tag, " address"}, vec_addr_o, e.addr);
               cur_due = 1'b1;
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(irq_o == 1'b0, "R11 irq", irq_o, 0);
      chk(vec_addr_o == 8'h03, "R11 addr", vec_addr_o, 8'h03);
      chk(cur_lvl_o == 2'd0, "R11 level", cur_lvl_o, 0);
      rst_n = 1'b1;
      glob_en_i = 1'b1;
      @(negedge clk);

      // R8: return with nothing in service; R7: stray acknowledge
      reti_pulse();
      cur_is(0, "R8 empty reti");
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      cur_is(0, "R7 stray ack level");
      chk(irq_o == 1'b0, "R7 stray ack irq", irq_o, 0);

      // R5 + R1: third source of vector 4 at low
      set_src(4, 2, 1'b1);
      service(4, 1, "R5 merged source / R1 vec4");
      set_src(4, 2, 1'b0);

      // R3 nesting: high above low
      raise_cfg_i[7] = 1'b1;
      set_src(7, 0, 1'b1);
      service(7, 2, "R3 nest high over low");
      set_src(7, 0, 1'b0);
      // R2: raised vector 2 is only high, so blocked at high
      raise_cfg_i[2] = 1'b1;
      set_src(2, 1, 1'b1);
      quiet(6, "R2 R3 equal level blocked");
      // R2: raised vector 1 is highest
      raise_cfg_i[1] = 1'b1;
      set_src(1, 0, 1'b1);
      service(1, 3, "R2 highest on vector 1");
      set_src(1, 0, 1'b0);
      reti_pulse();
      cur_is(2, "R8 restore high");
      quiet(3, "R3 still blocked at high");
      reti_pulse();
      service(2, 2, "R8 R3 high after restore to low");
      set_src(2, 1, 1'b0);
      reti_pulse();
      cur_is(1, "R8 restore low");
      reti_pulse();
      cur_is(0, "R8 restore none");

      // R4: equal level, lowest index wins
      raise_cfg_i = '0;
      set_src(8, 0, 1'b1);
      set_src(3, 1, 1'b1);
      service(3, 1, "R4 tie lowest index");
      set_src(3, 1, 1'b0);
      quiet(3, "R3 low blocked at low");
      reti_pulse();
      service(8, 1, "R4 loser served later");
      set_src(8, 0, 1'b0);
      reti_pulse();
      // R4: level beats index
      raise_cfg_i[9] = 1'b1;
      set_src(9, 0, 1'b1);
      set_src(1, 2, 1'b1);
      service(9, 2, "R4 level beats index");
      set_src(9, 0, 1'b0);
      reti_pulse();
      service(1, 1, "R4 lower level after");
      set_src(1, 2, 1'b0);
      reti_pulse();
      cur_is(0, "R8 back to none");

      // R10: masking keeps requests
      glob_en_i = 1'b0;
      set_src(6, 0, 1'b1);
      quiet(5, "R10 masked");
      glob_en_i = 1'b1;
      service(6, 1, "R10 offered after enable");
      set_src(6, 0, 1'b0);
      reti_pulse();
      set_src(5, 0, 1'b1);
      wait_irq("R10 pre-mask offer");
      glob_en_i = 1'b0;
      @(negedge clk);
      chk(irq_o == 1'b0, "R10 offer withdrawn", irq_o, 0);
      glob_en_i = 1'b1;
      service(5, 1, "R10 re-offer");
      set_src(5, 0, 1'b0);
      reti_pulse();

      // R6: offer frozen while a higher request arrives
      set_src(6, 1, 1'b1);
      wait_irq("R6 first offer");
      raise_cfg_i[0] = 1'b1;
      set_src(0, 0, 1'b1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(irq_o && vec_addr_o == 8'h33, "R6 vector held", vec_addr_o, 8'h33);
      end
      service(6, 1, "R6 frozen vector taken");
      set_src(6, 1, 1'b0);
      service(0, 3, "R6 R1 highest after");
      set_src(0, 0, 1'b0);
      reti_pulse();
      reti_pulse();
      cur_is(0, "R8 unwind");

      // R9: acknowledge and return in one edge
      raise_cfg_i = '0;
      set_src(4, 0, 1'b1);
      service(4, 1, "R9 setup low");
      set_src(4, 0, 1'b0);
      raise_cfg_i[7] = 1'b1;
      set_src(7, 2, 1'b1);
      begin
         exp_t e;
         e.addr = addr_of(7);
         e.lvl  = 2;
         e.tag  = "R9 ack with reti";
         q.push_back(e);
      end
      wait_irq("R9 offer");
      ack_i = 1'b1;
      reti_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      reti_i = 1'b0;
      set_src(7, 2, 1'b0);
      reti_pulse();
      cur_is(0, "R9 single return to none");

      repeat (3) @(negedge clk);
      chk(q.size() == 0, "R7 all offers accepted", q.size(), 0);
      finish_run();
   end

endmodule